// File: doc/BRIEF.md
# Data Transfer Abort Write Guard

This block sits beside the register file of a processor core and decides, beat by beat, whether a load or store instruction may still change architectural registers once the memory system has refused an access. It handles three instruction shapes: a single load or store (one beat), a register-list transfer (one beat per selected register), and an atomic exchange (a read beat followed by a write beat). On each beat it names the destination register and raises a write enable only when no abort has been seen in the instruction so far. At the end of the instruction it spends one finish cycle deciding the base-register write-back and passing an abort request on to the exception entry logic.

A list transfer never stops early. After an abort it keeps stepping through the remaining registers so that the address generator and memory side stay in step, but it suppresses every register write from the aborting beat onward. Registers go out in ascending index order, so the highest register (the program counter in a 16-entry file) is always last and is never overwritten by an aborted list load. A parameter selects one of two abort styles, and the only behaviour it changes is whether an aborted single transfer may still update its base register.

Top module: `xfer_abort_guard`

## Requirements
- R1: While reset is held and after it is released, busy_o, rf_we_o, wb_en_o, aborted_o and abt_req_o are all low.
- R2: A list transfer (op_i = 1) takes one beat per set bit of list_i, in ascending register index. On each beat rf_idx_o gives that register. A list load (load_i = 1) raises rf_we_o on every unaborted beat. A list store never raises it.
- R3: Once abort_i is high on a beat, rf_we_o stays low on that beat and on every later beat of the same instruction. The transfer still consumes every remaining beat, so the highest listed register is never written by an aborted list load.
- R4: For a list load whose base register (base_i) is in list_i and which completes without abort, wb_en_o stays low. If such a load aborts and wb_req_i is set, wb_en_o is raised.
- R5: A list transfer with wb_req_i set raises wb_en_o in its finish cycle whether or not it aborted, except in the unaborted base-in-list load case of R4. With wb_req_i clear, wb_en_o never rises.
- R6: A single transfer (op_i = 0, and op_i = 3 treated alike) takes one beat. A single load raises rf_we_o with rf_idx_o = dst_i when that beat does not abort. A single store never raises rf_we_o.
- R7: With LATE_ABORT = 0, an aborted single transfer never raises wb_en_o. With LATE_ABORT = 1, it raises wb_en_o when wb_req_i is set. An unaborted single transfer raises wb_en_o whenever wb_req_i is set, in both styles.
- R8: An exchange (op_i = 2) takes two beats. rf_we_o (with rf_idx_o = dst_i) rises only on the second beat, and only if neither beat aborted. An exchange never raises wb_en_o.
- R9: The finish cycle is the cycle after the last beat. aborted_o is high from the cycle after the aborting beat through the finish cycle. abt_req_o is high for exactly the finish cycle of an aborted instruction, and busy_o falls in the following cycle.
- R10: start_i is ignored while busy_o is high, and beat_i and abort_i are ignored while idle.
- R11: A list transfer with an empty list_i goes directly to its finish cycle with no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new instruction (accepted when idle) |
| op_i | input | 2 | 0 single, 1 list, 2 exchange, 3 treated as single |
| load_i | input | 1 | 1 for load, 0 for store (single and list) |
| list_i | input | NREG | Register selection mask for a list transfer |
| base_i | input | $clog2(NREG) | Base register index |
| dst_i | input | $clog2(NREG) | Destination register for single load and exchange |
| wb_req_i | input | 1 | Instruction asks for base write-back |
| beat_i | input | 1 | A memory beat completes this cycle |
| abort_i | input | 1 | The memory side refuses the current beat |
| busy_o | output | 1 | An instruction is in progress |
| rf_we_o | output | 1 | Register write enable for this beat |
| rf_idx_o | output | $clog2(NREG) | Register written on this beat |
| wb_en_o | output | 1 | Base write-back enable, finish cycle only |
| aborted_o | output | 1 | An abort has been seen in the current instruction |
| abt_req_o | output | 1 | Data-abort request pulse to exception entry |

## Verification
The bench sends an abort on the first, a middle and the last beat of list loads that include both the base register and the top register. A design that dropped only the aborting beat, ended the list early, or let the last register through would show a wrong write enable or a wrong busy length. Single transfers are aborted on two instances built in the two abort styles, which exposes a write-back decision that ignores the style or ignores the abort. Exchanges are aborted on each beat in turn to catch a read-beat abort being forgotten by the second beat. Starts raised during busy and beats raised while idle catch a design that accepts either one.

// File: rtl/xfer_abort_pkg.sv
package xfer_abort_pkg;

   typedef enum logic [1:0] {
      XOP_SINGLE = 2'd0,
      XOP_LIST   = 2'd1,
      XOP_SWAP   = 2'd2,
      XOP_RSVD   = 2'd3
   } xop_e;

   typedef enum logic [1:0] {
      XS_IDLE   = 2'd0,
      XS_RUN    = 2'd1,
      XS_FINISH = 2'd2
   } xstate_e;

endpackage

// File: rtl/xfer_list_walker.sv
// Holds the registers still to transfer; presents the lowest one each beat.
module xfer_list_walker #(
   parameter int NREG  = 16,
   parameter int IDX_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NREG-1:0]  load_mask,
   input  logic             step,
   output logic [IDX_W-1:0] cur_idx,
   output logic             last
);

   logic [NREG-1:0] rem_q;
   logic [NREG-1:0] clr_bit;

   always_comb begin
      cur_idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (rem_q[i]) cur_idx = IDX_W'(i);
      end
   end

   assign clr_bit = {{(NREG-1){1'b0}}, 1'b1} << cur_idx;
   assign last    = ((rem_q & (rem_q - 1'b1)) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    rem_q <= '0;
      else if (load) rem_q <= load_mask;
      else if (step) rem_q <= rem_q & ~clr_bit;
   end

endmodule

// File: rtl/xfer_wb_policy.sv
// Base write-back decision; the abort style picks the single-transfer rule.
module xfer_wb_policy #(
   parameter bit LATE_ABORT = 1'b0
) (
   input  logic is_list,
   input  logic is_swap,
   input  logic is_load,
   input  logic base_hit,
   input  logic aborted,
   input  logic wb_req,
   output logic wb_ok
);

   logic single_ok;

   generate
      if (LATE_ABORT) begin : g_late
         assign single_ok = 1'b1;
      end else begin : g_early
         assign single_ok = !aborted;
      end
   endgenerate

   always_comb begin
      if (!wb_req || is_swap) wb_ok = 1'b0;
      else if (is_list)       wb_ok = !(is_load && base_hit && !aborted);
      else                    wb_ok = single_ok;
   end

endmodule

// File: rtl/xfer_abort_guard.sv
module xfer_abort_guard
   import xfer_abort_pkg::*;
#(
   parameter int NREG       = 16,
   parameter bit LATE_ABORT = 1'b0,
   localparam int IDX_W     = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic             load_i,
   input  logic [NREG-1:0]  list_i,
   input  logic [IDX_W-1:0] base_i,
   input  logic [IDX_W-1:0] dst_i,
   input  logic             wb_req_i,
   input  logic             beat_i,
   input  logic             abort_i,
   output logic             busy_o,
   output logic             rf_we_o,
   output logic [IDX_W-1:0] rf_idx_o,
   output logic             wb_en_o,
   output logic             aborted_o,
   output logic             abt_req_o
);

   if (NREG < 2 || NREG > 64) begin : g_bad_nreg
      $error("xfer_abort_guard: NREG must lie in 2..64");
   end

   xstate_e          st_q;
   xop_e             op_q;
   logic             load_q, wb_q, ab_q, hit_q;
   logic [IDX_W-1:0] dst_q;

   logic             start_go, beat_go, blocked, writes_reg;
   logic             is_list, is_swap, wb_ok, last;
   logic [IDX_W-1:0] cur_idx;
   logic [NREG-1:0]  seed;

   assign start_go = (st_q == XS_IDLE) && start_i;
   assign beat_go  = (st_q == XS_RUN) && beat_i;
   assign is_list  = (op_q == XOP_LIST);
   assign is_swap  = (op_q == XOP_SWAP);

   always_comb begin
      unique case (xop_e'(op_i))
         XOP_LIST: seed = list_i;
         XOP_SWAP: seed = NREG'(2'b11);
         default:  seed = NREG'(1'b1);
      endcase
   end

   xfer_list_walker #(.NREG(NREG), .IDX_W(IDX_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_go),
      .load_mask (seed),
      .step      (beat_go),
      .cur_idx   (cur_idx),
      .last      (last)
   );

   xfer_wb_policy #(.LATE_ABORT(LATE_ABORT)) u_wb (
      .is_list  (is_list),
      .is_swap  (is_swap),
      .is_load  (load_q),
      .base_hit (hit_q),
      .aborted  (ab_q),
      .wb_req   (wb_q),
      .wb_ok    (wb_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= XS_IDLE;
         op_q   <= XOP_SINGLE;
         load_q <= 1'b0;
         wb_q   <= 1'b0;
         hit_q  <= 1'b0;
         dst_q  <= '0;
         ab_q   <= 1'b0;
      end else begin
         unique case (st_q)
            XS_IDLE: if (start_go) begin
               op_q   <= xop_e'(op_i);
               load_q <= load_i;
               wb_q   <= wb_req_i;
               hit_q  <= list_i[base_i];
               dst_q  <= dst_i;
               ab_q   <= 1'b0;
               st_q   <= (seed == '0) ? XS_FINISH : XS_RUN;
            end
            XS_RUN: if (beat_go) begin
               if (abort_i) ab_q <= 1'b1;
               if (last)    st_q <= XS_FINISH;
            end
            default: begin
               ab_q <= 1'b0;
               st_q <= XS_IDLE;
            end
         endcase
      end
   end

   assign blocked    = ab_q || abort_i;
   assign writes_reg = is_swap ? last : load_q;

   assign busy_o    = (st_q != XS_IDLE);
   assign rf_we_o   = beat_go && !blocked && writes_reg;
   assign rf_idx_o  = is_list ? cur_idx : dst_q;
   assign wb_en_o   = (st_q == XS_FINISH) && wb_ok;
   assign abt_req_o = (st_q == XS_FINISH) && ab_q;
   assign aborted_o = ab_q;

endmodule

// File: rtl/xfer_abort_guard_chk.sv
module xfer_abort_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic beat_i,
   input logic busy_o,
   input logic rf_we_o,
   input logic wb_en_o,
   input logic aborted_o,
   input logic abt_req_o
);

   // R3
   a_r3_no_write_once_aborted: assert property (@(posedge clk) disable iff (!rst_n)
      aborted_o |-> !rf_we_o);

   // R2
   a_r2_write_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (beat_i && busy_o));

   // R9
   a_r9_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      abt_req_o |-> aborted_o);

   // R9
   a_r9_flag_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(aborted_o) |-> !busy_o);

   // R9
   a_r9_req_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abt_req_o |=> (!busy_o && !abt_req_o));

   // R5
   a_r5_wb_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |=> !wb_en_o);

   // R5
   a_r5_wb_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> busy_o);

endmodule

bind xfer_abort_guard xfer_abort_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .beat_i    (beat_i),
   .busy_o    (busy_o),
   .rf_we_o   (rf_we_o),
   .wb_en_o   (wb_en_o),
   .aborted_o (aborted_o),
   .abt_req_o (abt_req_o)
);

// File: tb/xfer_abort_guard_tb.sv
`timescale 1ns/1ps
module xfer_abort_guard_tb;
   localparam int NREG  = 16;
   localparam int IDX_W = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n, start_i, load_i, wb_req_i, beat_i, abort_i;
   logic [1:0]       op_i;
   logic [NREG-1:0]  list_i;
   logic [IDX_W-1:0] base_i, dst_i;

   logic e_busy, e_we, e_wb, e_ab, e_req;
   logic l_busy, l_we, l_wb, l_ab, l_req;
   logic [IDX_W-1:0] e_idx, l_idx;

   xfer_abort_guard #(.NREG(NREG), .LATE_ABORT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .load_i(load_i),
      .list_i(list_i), .base_i(base_i), .dst_i(dst_i), .wb_req_i(wb_req_i),
      .beat_i(beat_i), .abort_i(abort_i), .busy_o(e_busy), .rf_we_o(e_we),
      .rf_idx_o(e_idx), .wb_en_o(e_wb), .aborted_o(e_ab), .abt_req_o(e_req));

   xfer_abort_guard #(.NREG(NREG), .LATE_ABORT(1'b1)) u_dut_late (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .load_i(load_i),
      .list_i(list_i), .base_i(base_i), .dst_i(dst_i), .wb_req_i(wb_req_i),
      .beat_i(beat_i), .abort_i(abort_i), .busy_o(l_busy), .rf_we_o(l_we),
      .rf_idx_o(l_idx), .wb_en_o(l_wb), .aborted_o(l_ab), .abt_req_o(l_req));

   int    checks = 0, errors = 0, ncyc = 0;
   string cur_req = "R1";

   // behavioural reference state
   int mst = 0;            // 0 idle, 1 run, 2 finish
   int mq[$];
   int mop = 0, mdst = 0;
   bit mload = 0, mwb = 0, mab = 0, mhit = 0;

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   function automatic bit exp_wb(bit late);
      if (mst != 2 || !mwb || mop == 2) return 0;
      if (mop == 1) return !(mload && mhit && !mab);
      return late ? 1'b1 : !mab;
   endfunction

   // one clock: compare before the edge, then advance the model at the edge
   task automatic cycle();
      bit beat, wr, we;
      int idx;
      #1;
      beat = (mst == 1) && beat_i;
      wr   = (mop == 2) ? (mq.size() == 1) : mload;
      we   = beat && !(mab || abort_i) && wr;
      idx  = (mop == 1 && mq.size() > 0) ? mq[0] : mdst;
      chk("busy early", e_busy, mst != 0);
      chk("busy late",  l_busy, mst != 0);
      chk("we early",   e_we, we);
      chk("we late",    l_we, we);
      if (we) begin
         chk("idx early", e_idx, idx);
         chk("idx late",  l_idx, idx);
      end
      chk("wb early",   e_wb, exp_wb(1'b0));
      chk("wb late",    l_wb, exp_wb(1'b1));
      chk("aborted early", e_ab, mab);
      chk("aborted late",  l_ab, mab);
      chk("req early",  e_req, (mst == 2) && mab);
      chk("req late",   l_req, (mst == 2) && mab);
      @(posedge clk);
      if (mst == 0 && start_i) begin
         mq.delete();
         mop = (op_i == 2'd3) ? 0 : int'(op_i);
         mload = load_i; mwb = wb_req_i; mdst = int'(dst_i);
         mhit = list_i[base_i]; mab = 0;
         if (mop == 1) begin
            for (int i = 0; i < NREG; i++) if (list_i[i]) mq.push_back(i);
         end else if (mop == 2) begin
            mq.push_back(0); mq.push_back(0);
         end else mq.push_back(0);
         mst = (mq.size() != 0) ? 1 : 2;
      end else if (mst == 1 && beat_i) begin
         if (abort_i) mab = 1;
         void'(mq.pop_front());
         if (mq.size() == 0) mst = 2;
      end else if (mst == 2) begin
         mst = 0; mab = 0;
      end
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      start_i = 0; op_i = 0; load_i = 0; list_i = '0; base_i = '0;
      dst_i = '0; wb_req_i = 0; beat_i = 0; abort_i = 0;
   endtask

   // ab_beat < 0 means no abort; gap inserts idle cycles between beats;
   // poke raises a conflicting start while busy (R10)
   task automatic run_xfer(string req, int op, bit ld, logic [NREG-1:0] lst,
                           int base, int dst, bit wb, int ab_beat, bit gap, bit poke);
      int bn = 0;
      bit toggle = 0;
      cur_req = req;
      start_i = 1; op_i = 2'(op); load_i = ld; list_i = lst;
      base_i = IDX_W'(base); dst_i = IDX_W'(dst); wb_req_i = wb;
      cycle();
      idle_inputs();
      for (int guard = 0; guard < 100 && mst != 0; guard++) begin
         toggle = !toggle;
         beat_i  = gap ? toggle : 1'b1;
         abort_i = beat_i && (bn == ab_beat);
         if (poke) begin
            start_i = 1; op_i = 2'd1; load_i = 1; list_i = '1; wb_req_i = 1;
         end
         if (mst == 1 && beat_i) bn++;
         cycle();
      end
      idle_inputs();
      cycle();
   endtask

   initial begin
      forever begin
         @(posedge clk);
         ncyc++;
         if (ncyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      @(negedge clk);
      cur_req = "R1";
      for (int i = 0; i < 3; i++) cycle();  // R1 reset state under reset
      rst_n = 1;
      cycle();                             // R1 after release

      // R2 list load, no abort, includes the top register
      run_xfer("R2", 1, 1, 16'h80F1, 3, 0, 1, -1, 0, 0);
      // R2 list store never writes
      run_xfer("R2", 1, 0, 16'h0F0F, 0, 0, 0, -1, 1, 0);
      // R3 abort mid list, top register listed and suppressed
      run_xfer("R3", 1, 1, 16'h8C0A, 1, 0, 0, 2, 0, 0);
      // R3 abort on the last beat only
      run_xfer("R3", 1, 1, 16'h8003, 0, 0, 0, 2, 1, 0);
      // R3 abort on first beat
      run_xfer("R3", 1, 1, 16'hFFFF, 4, 0, 1, 0, 0, 0);
      // R4 base in list, no abort: no write-back
      run_xfer("R4", 1, 1, 16'h0036, 2, 0, 1, -1, 0, 0);
      // R4 base in list, abort: write-back
      run_xfer("R4", 1, 1, 16'h0036, 2, 0, 1, 1, 0, 0);
      // R5 list store aborted with write-back
      run_xfer("R5", 1, 0, 16'h00F0, 5, 0, 1, 0, 0, 0);
      // R5 no write-back requested
      run_xfer("R5", 1, 1, 16'h0101, 9, 0, 0, 1, 0, 0);
      // R6 single load and store
      run_xfer("R6", 0, 1, '0, 2, 7, 0, -1, 1, 0);
      run_xfer("R6", 3, 1, '0, 2, 11, 0, -1, 0, 0);
      run_xfer("R6", 0, 0, '0, 2, 7, 0, -1, 0, 0);
      // R7 aborted singles: styles differ on write-back
      run_xfer("R7", 0, 1, '0, 6, 9, 1, 0, 0, 0);
      run_xfer("R7", 0, 0, '0, 6, 9, 1, 0, 1, 0);
      run_xfer("R7", 0, 1, '0, 6, 9, 1, -1, 0, 0);
      // R8 exchange clean, abort on read, abort on write
      run_xfer("R8", 2, 1, '0, 1, 12, 1, -1, 0, 0);
      run_xfer("R8", 2, 1, '0, 1, 12, 1, 0, 1, 0);
      run_xfer("R8", 2, 1, '0, 1, 12, 1, 1, 0, 0);
      // R9 abort flag and request timing with gapped beats
      run_xfer("R9", 1, 1, 16'h4211, 0, 0, 1, 1, 1, 0);
      // R10 start while busy ignored
      run_xfer("R10", 1, 1, 16'h0005, 0, 0, 0, -1, 0, 1);
      run_xfer("R10", 2, 1, '0, 0, 3, 0, 1, 1, 1);
      // R10 beat and abort while idle ignored
      cur_req = "R10";
      beat_i = 1; abort_i = 1;
      cycle(); cycle();
      idle_inputs();
      run_xfer("R10", 0, 1, '0, 0, 5, 1, -1, 0, 0);
      // R11 empty list goes straight to finish
      run_xfer("R11", 1, 1, '0, 0, 0, 1, -1, 0, 0);
      run_xfer("R11", 1, 0, '0, 0, 0, 0, -1, 0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule